// File: doc/BRIEF.md
# Error-Class Retry Sequencer

This block sits next to a command issuer and decides what to do once a command finishes. The issuer starts a command and raises a start strobe. When the command later completes, the issuer raises a completion strobe along with a done flag, an error-summary flag and a one-byte error code. The sequencer uses the upper nibble of that code to pick an outcome:

- finish with success;
- ask the issuer to run the same command again;
- ask for a controller reset and, once the reset is confirmed, ask for the retry;
- give up and report the code as the final status.

Each command may be tried only a limited number of times. A watchdog counts cycles while a command is outstanding. If it expires, the sequencer treats this as a failed attempt that needs a reset. A new command can begin only after the previous one has produced its final status.

Top module: `retry_seq`

## Requirements
- R1: After reset, `retry_o`, `rst_req_o` and `fin_o` are low and the block is idle. A completion that arrives while idle produces no output.
- R2: A valid completion (done = 1) with the error flag low, or with the error flag high and code 0x00, produces a one-cycle `fin_o` pulse in the next cycle. In that pulse `fin_ok_o` = 1 and `fin_code_o` = 0x00, whatever code bits were presented.
- R3: A valid error completion whose code has upper nibble 0x3 (already recovered) reports success: `fin_ok_o` = 1 and `fin_code_o` equals the code.
- R4: A valid error completion whose upper nibble is 0x1, 0x2, 0x9, 0xE, 0xF or any value other than 0x0, 0x3, 0x4 and 0x6 ends the command at once. `fin_o` pulses with `fin_ok_o` = 0 and `fin_code_o` equal to the code, and neither a retry nor a reset is requested.
- R5: Upper nibble 0x4 with attempts remaining produces a one-cycle `retry_o` pulse in the next cycle, with no final status and no reset request.
- R6: Upper nibble 0x6 with attempts remaining raises `rst_req_o` in the next cycle. It stays high until `rst_done_i` is sampled high. In the following cycle `rst_req_o` is low and `retry_o` pulses.
- R7: A command is tried at most `MAX_TRIES` (default 4) times. A retryable failure (nibble 0x4, nibble 0x6 or a timeout) on the last attempt ends the command: `fin_ok_o` = 0, `fin_code_o` carries the last error code (`TMO_CODE`, default 0x43, for a timeout), and no retry or reset is requested.
- R8: If no valid completion arrives within `TIMEOUT_CYC` cycles of a start or a retry, the sequencer takes the reset-then-retry path and counts one attempt. `rst_req_o` rises exactly `TIMEOUT_CYC` cycles after the start or retry edge.
- R9: A completion strobe with done = 0 is ignored: it causes no output and does not stop the watchdog.
- R10: A start strobe while a command is outstanding is ignored and does not restart the attempt count.
- R11: `fin_o` is a one-cycle pulse. `retry_o` never coincides with `fin_o` or with `rst_req_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | New command issued (accepted only when idle) |
| cmpl_i | input | 1 | Completion strobe |
| cmpl_done_i | input | 1 | Done flag that comes with the completion |
| cmpl_err_i | input | 1 | Error-summary flag, meaningful only when done is set |
| cmpl_code_i | input | 8 | Error code; the upper nibble selects the action |
| retry_o | output | 1 | One-cycle request to reissue the same command |
| rst_req_o | output | 1 | Controller reset request, held until acknowledged |
| rst_done_i | input | 1 | Reset has completed |
| fin_o | output | 1 | One-cycle final status strobe |
| fin_ok_o | output | 1 | Final status is success |
| fin_code_o | output | 8 | Final status code |

## Verification
The assertions assume that `rst_done_i` is raised only in answer to a pending `rst_req_o`. They also assume that completions signal command outcomes and do not arrive in the same cycle as a start. The stimulus keeps to both assumptions: it raises `rst_done_i` only after it has seen the request, and it separates each start from the following completion by at least one idle cycle. Every completion in the normal flow lands well inside the watchdog window, so a timeout happens only in the tests that wait for one on purpose.

// File: rtl/retry_pkg.sv
package retry_pkg;

    typedef enum logic [2:0] {
        ACT_OK,
        ACT_SOFT,
        ACT_RETRY,
        ACT_RESET,
        ACT_FAIL
    } act_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_RESET
    } st_e;

    typedef struct packed {
        logic       done;
        logic       err;
        logic [7:0] code;
    } cmpl_t;

    // Action chosen from the upper nibble of the error code
    function automatic act_e classify(input logic err, input logic [7:0] code);
        act_e a;
        if (!err) begin
            a = ACT_OK;
        end else begin
            case (code[7:4])
                4'h0:    a = ACT_OK;
                4'h3:    a = ACT_SOFT;
                4'h4:    a = ACT_RETRY;
                4'h6:    a = ACT_RESET;
                default: a = ACT_FAIL;
            endcase
        end
        return a;
    endfunction

endpackage

// File: rtl/retry_classify.sv
module retry_classify
    import retry_pkg::*;
(
    input  cmpl_t cmpl,
    output logic  vld,
    output act_e  act
);
    // The error flag is meaningful only when done is set
    assign vld = cmpl.done;
    assign act = classify(cmpl.err, cmpl.code);
endmodule

// File: rtl/retry_timer.sv
module retry_timer #(
    parameter int TIMEOUT_CYC = 400_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    output logic expire
);
    localparam int W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [W-1:0] LAST = W'(TIMEOUT_CYC - 1);

    logic [W-1:0] cnt;

    assign expire = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (run && !expire) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/retry_ctrl.sv
module retry_ctrl
    import retry_pkg::*;
#(
    parameter int         MAX_TRIES = 4,
    parameter logic [7:0] TMO_CODE  = 8'h43
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       cmpl_vld,
    input  act_e       act,
    input  logic [7:0] code,
    input  logic       expire,
    input  logic       rst_done_i,
    output logic       tmr_clr,
    output logic       tmr_run,
    output logic       retry_o,
    output logic       rst_req_o,
    output logic       fin_o,
    output logic       fin_ok_o,
    output logic [7:0] fin_code_o
);
    localparam int AW = $clog2(MAX_TRIES + 1);
    localparam logic [AW-1:0] LAST_TRY = AW'(MAX_TRIES);

    st_e           st;
    logic [AW-1:0] attempt;
    logic          last;
    logic          take_start;
    logic          take_cmpl;
    logic          reset_ack;
    logic          plain_retry;

    assign last        = (attempt == LAST_TRY);
    assign take_start  = (st == ST_IDLE) && start_i;
    assign take_cmpl   = (st == ST_WAIT) && cmpl_vld;
    assign reset_ack   = (st == ST_RESET) && rst_done_i;
    assign plain_retry = take_cmpl && (act == ACT_RETRY) && !last;
    assign tmr_clr     = take_start || reset_ack || plain_retry;
    assign tmr_run     = (st == ST_WAIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            attempt    <= '0;
            retry_o    <= 1'b0;
            rst_req_o  <= 1'b0;
            fin_o      <= 1'b0;
            fin_ok_o   <= 1'b0;
            fin_code_o <= 8'h00;
        end else begin
            retry_o <= 1'b0;
            fin_o   <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (take_start) begin
                        st      <= ST_WAIT;
                        attempt <= AW'(1);
                    end
                end
                ST_WAIT: begin
                    if (cmpl_vld) begin
                        case (act)
                            ACT_OK: begin
                                fin_o      <= 1'b1;
                                fin_ok_o   <= 1'b1;
                                fin_code_o <= 8'h00;
                                st         <= ST_IDLE;
                            end
                            ACT_SOFT: begin
                                fin_o      <= 1'b1;
                                fin_ok_o   <= 1'b1;
                                fin_code_o <= code;
                                st         <= ST_IDLE;
                            end
                            ACT_RETRY, ACT_RESET: begin
                                if (last) begin
                                    fin_o      <= 1'b1;
                                    fin_ok_o   <= 1'b0;
                                    fin_code_o <= code;
                                    st         <= ST_IDLE;
                                end else begin
                                    attempt <= attempt + 1'b1;
                                    if (act == ACT_RETRY) begin
                                        retry_o <= 1'b1;
                                    end else begin
                                        rst_req_o <= 1'b1;
                                        st        <= ST_RESET;
                                    end
                                end
                            end
                            default: begin
                                fin_o      <= 1'b1;
                                fin_ok_o   <= 1'b0;
                                fin_code_o <= code;
                                st         <= ST_IDLE;
                            end
                        endcase
                    end else if (expire) begin
                        if (last) begin
                            fin_o      <= 1'b1;
                            fin_ok_o   <= 1'b0;
                            fin_code_o <= TMO_CODE;
                            st         <= ST_IDLE;
                        end else begin
                            attempt   <= attempt + 1'b1;
                            rst_req_o <= 1'b1;
                            st        <= ST_RESET;
                        end
                    end
                end
                ST_RESET: begin
                    if (rst_done_i) begin
                        rst_req_o <= 1'b0;
                        retry_o   <= 1'b1;
                        st        <= ST_WAIT;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/retry_seq.sv
module retry_seq
    import retry_pkg::*;
#(
    parameter int         MAX_TRIES   = 4,
    parameter int         TIMEOUT_CYC = 400_000_000,
    parameter logic [7:0] TMO_CODE    = 8'h43
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       cmpl_i,
    input  logic       cmpl_done_i,
    input  logic       cmpl_err_i,
    input  logic [7:0] cmpl_code_i,
    output logic       retry_o,
    output logic       rst_req_o,
    input  logic       rst_done_i,
    output logic       fin_o,
    output logic       fin_ok_o,
    output logic [7:0] fin_code_o
);
    cmpl_t cmpl;
    logic  done_vld;
    act_e  act;
    logic  tmr_clr;
    logic  tmr_run;
    logic  expire;

    assign cmpl = '{done: cmpl_i && cmpl_done_i, err: cmpl_err_i, code: cmpl_code_i};

    retry_classify u_cls (
        .cmpl (cmpl),
        .vld  (done_vld),
        .act  (act)
    );

    retry_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .clr    (tmr_clr),
        .run    (tmr_run),
        .expire (expire)
    );

    retry_ctrl #(.MAX_TRIES(MAX_TRIES), .TMO_CODE(TMO_CODE)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .cmpl_vld   (done_vld),
        .act        (act),
        .code       (cmpl_code_i),
        .expire     (expire),
        .rst_done_i (rst_done_i),
        .tmr_clr    (tmr_clr),
        .tmr_run    (tmr_run),
        .retry_o    (retry_o),
        .rst_req_o  (rst_req_o),
        .fin_o      (fin_o),
        .fin_ok_o   (fin_ok_o),
        .fin_code_o (fin_code_o)
    );
endmodule

// File: rtl/retry_seq_chk.sv
module retry_seq_chk #(
    parameter int MAX_TRIES = 4
) (
    input logic       clk,
    input logic       rst,
    input logic       cmpl_i,
    input logic       cmpl_done_i,
    input logic       cmpl_err_i,
    input logic [7:0] cmpl_code_i,
    input logic       retry_o,
    input logic       rst_req_o,
    input logic       rst_done_i,
    input logic       fin_o,
    input logic       fin_ok_o,
    input logic [7:0] fin_code_o
);
    logic       err_in;
    logic [3:0] nib;
    logic       fail_cls;
    logic [7:0] retries;

    assign err_in   = cmpl_i && cmpl_done_i && cmpl_err_i;
    assign nib      = cmpl_code_i[7:4];
    assign fail_cls = (nib != 4'h0) && (nib != 4'h3) && (nib != 4'h4) && (nib != 4'h6);

    always_ff @(posedge clk) begin
        if (rst || fin_o) retries <= 8'd0;
        else if (retry_o) retries <= retries + 8'd1;
    end

    AST_FIN_PULSE: assert property (@(posedge clk) disable iff (rst) fin_o |=> !fin_o); // R11
    AST_RETRY_EXCL: assert property (@(posedge clk) disable iff (rst) !(retry_o && (fin_o || rst_req_o))); // R11
    AST_OK_CODE: assert property (@(posedge clk) disable iff (rst) (fin_o && fin_ok_o) |-> (fin_code_o == 8'h00 || fin_code_o[7:4] == 4'h3)); // R3
    AST_FAIL_CODE: assert property (@(posedge clk) disable iff (rst) (fin_o && !fin_ok_o) |-> (fin_code_o[7:4] != 4'h0 && fin_code_o[7:4] != 4'h3)); // R4
    AST_FAIL_NO_RETRY: assert property (@(posedge clk) disable iff (rst) (err_in && fail_cls && !rst_req_o) |=> (!retry_o && !rst_req_o)); // R4
    AST_HARD_NO_RESET: assert property (@(posedge clk) disable iff (rst) (err_in && nib == 4'h4 && !rst_req_o) |=> !rst_req_o); // R5
    AST_RST_HOLD: assert property (@(posedge clk) disable iff (rst) (rst_req_o && !rst_done_i) |=> rst_req_o); // R6
    AST_RST_EXIT: assert property (@(posedge clk) disable iff (rst) (rst_req_o && rst_done_i) |=> (!rst_req_o && retry_o)); // R6
    AST_TRY_LIMIT: assert property (@(posedge clk) disable iff (rst) retry_o |-> (retries < 8'(MAX_TRIES - 1))); // R7
endmodule

bind retry_seq retry_seq_chk #(.MAX_TRIES(MAX_TRIES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmpl_i      (cmpl_i),
    .cmpl_done_i (cmpl_done_i),
    .cmpl_err_i  (cmpl_err_i),
    .cmpl_code_i (cmpl_code_i),
    .retry_o     (retry_o),
    .rst_req_o   (rst_req_o),
    .rst_done_i  (rst_done_i),
    .fin_o       (fin_o),
    .fin_ok_o    (fin_ok_o),
    .fin_code_o  (fin_code_o)
);

// File: tb/retry_seq_tb.sv
`timescale 1ns/1ps
module retry_seq_tb;
    localparam int         TRIES = 4;
    localparam int         TMO   = 20;
    localparam logic [7:0] TCODE = 8'h43;

    logic       clk = 1'b0;
    logic       rst;
    logic       start_i, cmpl_i, cmpl_done_i, cmpl_err_i, rst_done_i;
    logic [7:0] cmpl_code_i;
    logic       retry_o, rst_req_o, fin_o, fin_ok_o;
    logic [7:0] fin_code_o;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #2 clk = ~clk;

    retry_seq #(.MAX_TRIES(TRIES), .TIMEOUT_CYC(TMO), .TMO_CODE(TCODE)) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .cmpl_i(cmpl_i),
        .cmpl_done_i(cmpl_done_i), .cmpl_err_i(cmpl_err_i), .cmpl_code_i(cmpl_code_i),
        .retry_o(retry_o), .rst_req_o(rst_req_o), .rst_done_i(rst_done_i),
        .fin_o(fin_o), .fin_ok_o(fin_ok_o), .fin_code_o(fin_code_o)
    );

    // {code[8], err, kind[2] (0 final, 1 retry, 2 reset), ok, exp_code[8]}
    localparam int NV = 14;
    localparam logic [19:0] VEC [NV] = '{
        {8'h00, 1'b0, 2'd0, 1'b1, 8'h00},
        {8'h5A, 1'b0, 2'd0, 1'b1, 8'h00},
        {8'h00, 1'b1, 2'd0, 1'b1, 8'h00},
        {8'h31, 1'b1, 2'd0, 1'b1, 8'h31},
        {8'h3F, 1'b1, 2'd0, 1'b1, 8'h3F},
        {8'h12, 1'b1, 2'd0, 1'b0, 8'h12},
        {8'h2C, 1'b1, 2'd0, 1'b0, 8'h2C},
        {8'h90, 1'b1, 2'd0, 1'b0, 8'h90},
        {8'hE5, 1'b1, 2'd0, 1'b0, 8'hE5},
        {8'hF0, 1'b1, 2'd0, 1'b0, 8'hF0},
        {8'h55, 1'b1, 2'd0, 1'b0, 8'h55},
        {8'h8B, 1'b1, 2'd0, 1'b0, 8'h8B},
        {8'h43, 1'b1, 2'd1, 1'b0, 8'h00},
        {8'h64, 1'b1, 2'd2, 1'b0, 8'h00}
    };

    function automatic string tag(input logic err, input logic [7:0] c);
        if (!err || c[7:4] == 4'h0) return "R2";
        case (c[7:4])
            4'h3:    return "R3";
            4'h4:    return "R5";
            4'h6:    return "R6";
            default: return "R4";
        endcase
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    task automatic complete(input logic d, input logic e, input logic [7:0] c);
        @(negedge clk);
        cmpl_i = 1'b1; cmpl_done_i = d; cmpl_err_i = e; cmpl_code_i = c;
        @(negedge clk);
        cmpl_i = 1'b0; cmpl_done_i = 1'b0; cmpl_err_i = 1'b0; cmpl_code_i = 8'h00;
    endtask

    task automatic ack_reset();
        @(negedge clk) rst_done_i = 1'b1;
        @(negedge clk) rst_done_i = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        rst = 1'b1; start_i = 1'b0; cmpl_i = 1'b0; cmpl_done_i = 1'b0;
        cmpl_err_i = 1'b0; cmpl_code_i = 8'h00; rst_done_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state, idle completion ignored
        chk("R1 retry", {7'd0, retry_o}, 8'd0);
        chk("R1 rst_req", {7'd0, rst_req_o}, 8'd0);
        chk("R1 fin", {7'd0, fin_o}, 8'd0);
        complete(1'b1, 1'b1, 8'h41);
        chk("R1 idle cmpl fin", {7'd0, fin_o}, 8'd0);
        chk("R1 idle cmpl retry", {7'd0, retry_o}, 8'd0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            logic [7:0] c;
            logic       e, ok;
            logic [1:0] k;
            logic [7:0] ec;
            string      t;
            {c, e, k, ok, ec} = VEC[i];
            t = tag(e, c);
            do_start();
            complete(1'b1, e, c);
            if (k == 2'd0) begin
                chk({t, " fin"}, {7'd0, fin_o}, 8'd1);
                chk({t, " ok"}, {7'd0, fin_ok_o}, {7'd0, ok});
                chk({t, " code"}, fin_code_o, ec);
                chk({t, " no retry"}, {6'd0, retry_o, rst_req_o}, 8'd0);
                @(negedge clk);
                chk("R11 fin pulse", {7'd0, fin_o}, 8'd0);
            end else if (k == 2'd1) begin
                chk("R5 retry", {7'd0, retry_o}, 8'd1);
                chk("R5 no fin/reset", {6'd0, fin_o, rst_req_o}, 8'd0);
                complete(1'b1, 1'b0, 8'h00);
                chk("R5 then ok", {6'd0, fin_o, fin_ok_o}, 8'd3);
            end else begin
                chk("R6 rst_req", {6'd0, rst_req_o, retry_o}, 8'd2);
                @(negedge clk);
                chk("R6 held", {7'd0, rst_req_o}, 8'd1);
                ack_reset();
                chk("R6 released+retry", {6'd0, rst_req_o, retry_o}, 8'd1);
                complete(1'b1, 1'b0, 8'h00);
                chk("R6 then ok", {6'd0, fin_o, fin_ok_o}, 8'd3);
            end
        end

        // R7: four attempts with mixed hard errors, last one reset-class
        do_start();
        complete(1'b1, 1'b1, 8'h40);
        chk("R7 try1 retry", {7'd0, retry_o}, 8'd1);
        complete(1'b1, 1'b1, 8'h61);
        chk("R7 try2 reset", {7'd0, rst_req_o}, 8'd1);
        ack_reset();
        complete(1'b1, 1'b1, 8'h45);
        chk("R7 try3 retry", {7'd0, retry_o}, 8'd1);
        complete(1'b1, 1'b1, 8'h66);
        chk("R7 try4 final", {6'd0, fin_o, fin_ok_o}, 8'd2);
        chk("R7 last code", fin_code_o, 8'h66);
        chk("R7 no reset", {6'd0, rst_req_o, retry_o}, 8'd0);

        // R9: completion without done is ignored
        do_start();
        complete(1'b0, 1'b1, 8'h41);
        chk("R9 ignored", {5'd0, fin_o, retry_o, rst_req_o}, 8'd0);
        complete(1'b1, 1'b0, 8'h00);
        chk("R9 later ok", {6'd0, fin_o, fin_ok_o}, 8'd3);

        // R10: start while busy does not restart the attempt count
        do_start();
        complete(1'b1, 1'b1, 8'h40);
        complete(1'b1, 1'b1, 8'h40);
        do_start();
        complete(1'b1, 1'b1, 8'h40);
        chk("R10 third retry", {7'd0, retry_o}, 8'd1);
        complete(1'b1, 1'b1, 8'h47);
        chk("R10 fourth final", {6'd0, fin_o, fin_ok_o}, 8'd2);
        chk("R10 code", fin_code_o, 8'h47);

        // R8: watchdog timeout, then exhaustion by timeout (R7)
        do_start();
        repeat (TMO - 1) @(negedge clk);
        chk("R8 before timeout", {7'd0, rst_req_o}, 8'd0);
        @(negedge clk);
        chk("R8 timeout reset", {7'd0, rst_req_o}, 8'd1);
        ack_reset();
        chk("R8 retry after reset", {7'd0, retry_o}, 8'd1);
        complete(1'b1, 1'b1, 8'h41);
        chk("R8 try3 retry", {7'd0, retry_o}, 8'd1);
        complete(1'b1, 1'b1, 8'h62);
        chk("R8 try4 reset", {7'd0, rst_req_o}, 8'd1);
        ack_reset();
        repeat (TMO - 1) @(negedge clk);
        chk("R8 no early final", {7'd0, fin_o}, 8'd0);
        @(negedge clk);
        chk("R7 timeout final", {6'd0, fin_o, fin_ok_o}, 8'd2);
        chk("R7 timeout code", fin_code_o, TCODE);
        chk("R7 timeout no reset", {7'd0, rst_req_o}, 8'd0);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule